// File: doc/BRIEF.md
# Dual-Phase Sample FIFO Writer

This block takes one wide converter sample per conversion period and turns it into two consecutive writes into a narrower FIFO. A free-running phase, produced by halving the write clock, alternates between a direct phase and a held phase. A sample offered in the direct phase has its lower half written to the FIFO in the same cycle. Its upper half is caught in a holding register and written in the held phase that follows. A conversion period is therefore two clocks long, and the FIFO receives exactly two words for each sample it accepts.

The packed sample is `{smp_range, smp_data}`: the two out-of-range flags sit in the top bits, above the 24 data bits. The FIFO word is `WORD_W = ceil((DATA_W+FLAG_W)/2)` bits wide, which is 13 with the defaults. The upper half is zero-padded when the packed width is odd. The FIFO tells the block through `fifo_nospace` that it cannot take two more words. In that case a sample offered in the direct phase is dropped whole and a sticky overflow flag is set. When the FIFO reports half full, an interrupt request is raised for the host, and the request is held until the host acknowledges it.

The phase state machine has three states. PH_DIRECT is the direct phase. From it, the machine goes to PH_HELD_WR when a sample is accepted, and to PH_HELD_SKIP when no sample is accepted (none offered, or FIFO without space). Both PH_HELD_WR and PH_HELD_SKIP return to PH_DIRECT unconditionally. Reset places the machine in PH_DIRECT.

Top module: `sample_fifo_writer`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, the state is PH_DIRECT; `fifo_we`, `irq_req` and `ovf_flag` are 0.
- R2: In a direct-phase cycle with `smp_valid`=1 and `fifo_nospace`=0, `fifo_we`=1 in that same cycle and `fifo_wdata` equals packed bits [12:0], i.e. `smp_data[12:0]`.
- R3: In the cycle after an accepted sample, `fifo_we`=1 and `fifo_wdata` equals packed bits [25:13], i.e. `{smp_range[1:0], smp_data[23:13]}` as they were at acceptance, whatever the inputs are now.
- R4: The phase alternates every clock regardless of the inputs. A `smp_valid` during the held phase is ignored: it causes no write in that cycle or the next.
- R5: In a direct-phase cycle with `smp_valid`=1 and `fifo_nospace`=1, no write happens in that cycle or the next, and `ovf_flag` becomes 1 on the following cycle.
- R6: Once set, `ovf_flag` stays 1 until reset, whatever later traffic occurs.
- R7: The held write of an accepted sample happens even if `fifo_nospace` rises during the held phase, so the two halves are never separated.
- R8: `irq_req` becomes 1 in the cycle after `fifo_half`=1 is seen without `irq_ack`. It then stays 1, even after `fifo_half` falls, until it is acknowledged.
- R9: `irq_ack`=1 makes `irq_req` 0 in the next cycle and takes priority over `fifo_half` in that cycle. If `fifo_half` is still 1 in a later cycle without acknowledge, the request rises again.
- R10: In a direct-phase cycle with `smp_valid`=0 no write happens, and none follows in the held phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A converter sample is offered this cycle |
| smp_data | input | DATA_W | Converter sample value |
| smp_range | input | FLAG_W | Converter out-of-range flags |
| fifo_nospace | input | 1 | FIFO cannot accept two more words |
| fifo_half | input | 1 | FIFO is at least half full |
| irq_ack | input | 1 | Host acknowledge of the interrupt request |
| fifo_wdata | output | WORD_W | Word presented to the FIFO |
| fifo_we | output | 1 | FIFO write strobe |
| irq_req | output | 1 | Interrupt request to the host side |
| ovf_flag | output | 1 | Sticky flag: a sample was dropped for lack of space |

## Verification
The writer is driven with single samples separated by idle cycles, with samples offered every clock (so that held-phase offers must be ignored), and with data whose two halves differ so that a swapped or stale half shows up. Blocking by `fifo_nospace` is applied separately in the direct phase and in the held phase: the first distinguishes a dropped whole sample from a split one, and the second shows that a half already committed is still completed. Interrupt traffic covers a short half-full pulse, an acknowledge with half-full low and with half-full high, and a long mixed random stretch in which every port is compared each cycle with a behavioural model.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    typedef enum logic [1:0] {
        PH_DIRECT    = 2'd0,
        PH_HELD_WR   = 2'd1,
        PH_HELD_SKIP = 2'd2
    } wr_state_e;

endpackage

// File: rtl/sfw_phase_fsm.sv
module sfw_phase_fsm
    import sfw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic fifo_nospace,
    output logic direct_ph,
    output logic take_smp,
    output logic drop_smp,
    output logic wr_en
);

    wr_state_e st_q, st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_DIRECT;
        else        st_q <= st_nx;
    end

    // next state: the phase toggles every clock
    always_comb begin
        st_nx = PH_DIRECT;
        unique case (st_q)
            PH_DIRECT:    st_nx = (smp_valid && !fifo_nospace) ? PH_HELD_WR : PH_HELD_SKIP;
            PH_HELD_WR:   st_nx = PH_DIRECT;
            PH_HELD_SKIP: st_nx = PH_DIRECT;
            default:      st_nx = PH_DIRECT;
        endcase
    end

    // outputs
    always_comb begin
        direct_ph = 1'b0;
        take_smp  = 1'b0;
        drop_smp  = 1'b0;
        wr_en     = 1'b0;
        unique case (st_q)
            PH_DIRECT: begin
                direct_ph = 1'b1;
                take_smp  = smp_valid && !fifo_nospace;
                drop_smp  = smp_valid && fifo_nospace;
                wr_en     = smp_valid && !fifo_nospace;
            end
            PH_HELD_WR:   wr_en = 1'b1;
            PH_HELD_SKIP: wr_en = 1'b0;
            default:      wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfw_split_path.sv
module sfw_split_path #(
    parameter int SAMPLE_W = 26,
    parameter int WORD_W   = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                capture,
    input  logic                direct_ph,
    output logic [WORD_W-1:0]   wdata
);

    localparam int HI_W = SAMPLE_W - WORD_W;

    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;
    logic [WORD_W-1:0] hold_q;

    assign lo_word = sample[WORD_W-1:0];

    generate
        if (HI_W < WORD_W) begin : g_pad
            assign hi_word = {{(WORD_W-HI_W){1'b0}}, sample[SAMPLE_W-1:WORD_W]};
        end else begin : g_nopad
            assign hi_word = sample[SAMPLE_W-1:WORD_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= hi_word;
    end

    assign wdata = direct_ph ? lo_word : hold_q;

endmodule

// File: rtl/sfw_event_flags.sv
module sfw_event_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic drop_smp,
    input  logic fifo_half,
    input  logic irq_ack,
    output logic irq_req,
    output logic ovf_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_req <= 1'b0;
        else if (irq_ack)   irq_req <= 1'b0;
        else if (fifo_half) irq_req <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (drop_smp) ovf_flag <= 1'b1;
    end

endmodule

// File: rtl/sample_fifo_writer.sv
module sample_fifo_writer #(
    parameter int DATA_W = 24,
    parameter int FLAG_W = 2,
    localparam int SAMPLE_W = DATA_W + FLAG_W,
    localparam int WORD_W   = (SAMPLE_W + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [FLAG_W-1:0] smp_range,
    input  logic              fifo_nospace,
    input  logic              fifo_half,
    input  logic              irq_ack,
    output logic [WORD_W-1:0] fifo_wdata,
    output logic              fifo_we,
    output logic              irq_req,
    output logic              ovf_flag
);

    logic direct_ph;
    logic take_smp;
    logic drop_smp;

    sfw_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .fifo_nospace (fifo_nospace),
        .direct_ph    (direct_ph),
        .take_smp     (take_smp),
        .drop_smp     (drop_smp),
        .wr_en        (fifo_we)
    );

    sfw_split_path #(
        .SAMPLE_W (SAMPLE_W),
        .WORD_W   (WORD_W)
    ) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    ({smp_range, smp_data}),
        .capture   (take_smp),
        .direct_ph (direct_ph),
        .wdata     (fifo_wdata)
    );

    sfw_event_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .drop_smp  (drop_smp),
        .fifo_half (fifo_half),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .ovf_flag  (ovf_flag)
    );

endmodule

// File: rtl/sfw_checker.sv
module sfw_checker #(
    parameter int DATA_W = 24,
    parameter int FLAG_W = 2
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     smp_valid,
    input logic [DATA_W-1:0]                        smp_data,
    input logic [FLAG_W-1:0]                        smp_range,
    input logic                                     fifo_nospace,
    input logic                                     fifo_half,
    input logic                                     irq_ack,
    input logic [(DATA_W+FLAG_W+1)/2-1:0]           fifo_wdata,
    input logic                                     fifo_we,
    input logic                                     irq_req,
    input logic                                     ovf_flag
);

    localparam int SW = DATA_W + FLAG_W;
    localparam int WW = (SW + 1) / 2;

    logic [SW-1:0] pk;
    logic          ph_c;   // 0 = direct phase, tracked independently

    assign pk = {smp_range, smp_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_c <= 1'b0;
        else        ph_c <= ~ph_c;
    end

    always_comb begin
        if (!rst_n) AST_RESET_QUIET: assert (!irq_req && !ovf_flag); // R1
    end

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph_c && smp_valid && !fifo_nospace) |-> (fifo_we && fifo_wdata == pk[WW-1:0])); // R2

    AST_HELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph_c && smp_valid && !fifo_nospace) |=> fifo_we); // R3

    AST_HELD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_c && smp_valid) |=> (fifo_we == (smp_valid && !fifo_nospace))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph_c && smp_valid && fifo_nospace) |-> !fifo_we ##1 (!fifo_we && ovf_flag)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R6

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_half && !irq_ack) |=> irq_req); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req); // R8

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_req); // R9

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph_c && !smp_valid) |-> !fifo_we ##1 !fifo_we); // R10

endmodule

bind sample_fifo_writer sfw_checker #(
    .DATA_W (DATA_W),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .smp_range    (smp_range),
    .fifo_nospace (fifo_nospace),
    .fifo_half    (fifo_half),
    .irq_ack      (irq_ack),
    .fifo_wdata   (fifo_wdata),
    .fifo_we      (fifo_we),
    .irq_req      (irq_req),
    .ovf_flag     (ovf_flag)
);

// File: tb/sample_fifo_writer_tb.sv
`timescale 1ns/1ps
module sample_fifo_writer_tb;

    localparam int DW = 24;
    localparam int FW = 2;
    localparam int WW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [FW-1:0] smp_range = '0;
    logic          fifo_nospace = 1'b0;
    logic          fifo_half = 1'b0;
    logic          irq_ack = 1'b0;
    logic [WW-1:0] fifo_wdata;
    logic          fifo_we;
    logic          irq_req;
    logic          ovf_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit            m_ph = 1'b0;
    bit            m_pend = 1'b0;
    logic [WW-1:0] m_held = '0;
    bit            m_irq = 1'b0;
    bit            m_ovf = 1'b0;

    always #2.5 clk = ~clk;

    sample_fifo_writer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .smp_range    (smp_range),
        .fifo_nospace (fifo_nospace),
        .fifo_half    (fifo_half),
        .irq_ack      (irq_ack),
        .fifo_wdata   (fifo_wdata),
        .fifo_we      (fifo_we),
        .irq_req      (irq_req),
        .ovf_flag     (ovf_flag)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(bit v, logic [DW-1:0] d, logic [FW-1:0] r, bit full,
                        bit half, bit ack, string tag);
        logic [DW+FW-1:0] pk;
        bit exp_we;
        @(negedge clk);
        smp_valid = v; smp_data = d; smp_range = r;
        fifo_nospace = full; fifo_half = half; irq_ack = ack;
        #1;
        pk = {r, d};
        exp_we = (m_ph == 1'b0) ? (v && !full) : m_pend;
        chk(tag, "we", 32'(fifo_we), 32'(exp_we));
        if (exp_we)
            chk(tag, "wdata", 32'(fifo_wdata), (m_ph == 1'b0) ? 32'(pk[WW-1:0]) : 32'(m_held));
        chk(tag, "irq", 32'(irq_req), 32'(m_irq));
        chk(tag, "ovf", 32'(ovf_flag), 32'(m_ovf));
        @(posedge clk);
        if (m_ph == 1'b0) begin
            m_pend = v && !full;
            if (v && !full) m_held = pk[DW+FW-1:WW];
            if (v && full) m_ovf = 1'b1;
        end else begin
            m_pend = 1'b0;
        end
        m_ph = ~m_ph;
        if (ack) m_irq = 1'b0;
        else if (half) m_irq = 1'b1;
    endtask

    task automatic idle(string tag);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // align to the direct phase, then offer a sample; held-phase inputs are noise
    task automatic put_sample(logic [DW-1:0] d, logic [FW-1:0] r, bit held_v,
                              bit held_full, string tag_a, string tag_b);
        if (m_ph) idle(tag_a);
        step(1'b1, d, r, 1'b0, 1'b0, 1'b0, tag_a);
        step(held_v, ~d, ~r, held_full, 1'b0, 1'b0, tag_b);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "we in reset", 32'(fifo_we), 32'd0);
        chk("R1", "irq in reset", 32'(irq_req), 32'd0);
        chk("R1", "ovf in reset", 32'(ovf_flag), 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, "R1");

        // R10: nothing offered, nothing written
        for (int i = 0; i < 4; i++) idle("R10");

        // R2 / R3: samples with distinct halves
        put_sample(24'hFFFFFF, 2'b11, 1'b0, 1'b0, "R2", "R3");
        put_sample(24'h000000, 2'b00, 1'b0, 1'b0, "R2", "R3");
        put_sample(24'hABC123, 2'b10, 1'b0, 1'b0, "R2", "R3");
        put_sample(24'h5A5A5A, 2'b01, 1'b1, 1'b0, "R2", "R3");

        // R4: valid held high every clock with changing data
        for (int i = 0; i < 12; i++)
            step(1'b1, 24'(i * 24'h13579B + 24'h2468), 2'(i), 1'b0, 1'b0, 1'b0, "R4");

        // R5: no space in the direct phase drops the whole sample
        if (m_ph) idle("R5");
        step(1'b1, 24'h123456, 2'b01, 1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 24'h654321, 2'b10, 1'b0, 1'b0, 1'b0, "R5");
        idle("R5");

        // R6: flag stays set under later clean traffic
        put_sample(24'h0F0F0F, 2'b00, 1'b0, 1'b0, "R6", "R6");
        for (int i = 0; i < 5; i++) idle("R6");

        // R7: space vanishes during the held phase
        put_sample(24'hC0FFEE, 2'b11, 1'b1, 1'b1, "R7", "R7");
        put_sample(24'h1F2E3D, 2'b01, 1'b0, 1'b1, "R7", "R7");

        // R8: short half-full pulse, request holds
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 5; i++) idle("R8");

        // R9: acknowledge clears; priority over half-full; re-raise
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, "R9");
        idle("R9");
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, "R9");
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, "R9");
        idle("R9");

        // mixed random traffic against the model
        for (int i = 0; i < 4000; i++)
            step(1'($urandom % 2), 24'($urandom), 2'($urandom),
                 ($urandom % 7) == 0, ($urandom % 9) == 0, ($urandom % 6) == 0, "R2");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule